// File: doc/BRIEF.md
# Formatted Value Text Printer

The printer takes one unsigned binary value at a time and turns it into a fixed line of ASCII text. It sends the text one character per transfer on an 8-bit valid/ready output stream. The text is set at elaboration. It is built from constant text pieces, with numeric fields between them. Each field shows the same accepted value in one radix, with a fixed number of digits. Hex digits come straight from 4-bit slices of the value, octal from 3-bit slices and binary from single bits. Decimal digits come from a sequential binary-to-BCD converter, which runs while the earlier text is being sent.

The line is, in order:

- `hex 0x`, then 8 lowercase hex digits
- `, dec `, then 10 decimal digits
- `, HEX `, then 8 uppercase hex digits
- `, oct `, then 11 octal digits
- `, bin `, then 8 binary digits
- a closing `.`

That makes 76 characters. No terminating zero is sent. Instead, the final character is flagged with `out_last`.

Back-pressure works as follows:

- The input side takes a new value only while no line is in progress. It raises `in_ready` again in the cycle after the final character has been accepted downstream.
- On the output side, a character that is offered (`out_valid` high) stays unchanged until `out_ready` takes it.
- `out_valid` may drop while the output sits on a decimal digit and the converter has not finished.

Top module: `strfmt_emitter`

## Requirements
- R1: `in_ready` is high exactly when no line is in progress. A value is latched when `in_valid` and `in_ready` are both high at a clock edge. `in_valid` and `in_data` are ignored while a line is being sent, and the line shows the latched value.
- R2: Each line is exactly the 76 characters described above, in that order. The constant text uses plain ASCII codes.
- R3: Both hex fields show the value's 8 nibbles, most significant first. Digits 0-9 are codes 0x30-0x39. Values 10-15 are codes 0x61-0x66 in the lowercase field and 0x41-0x46 in the uppercase field.
- R4: The decimal field has 10 digits, most significant first. Leading positions are filled with '0' (0x30), so 0 prints as ten '0' characters and 0xFFFFFFFF prints as 4294967295.
- R5: The octal field has 11 digits, most significant first, with the value zero-extended above bit 31. The binary field has 8 digits and shows bits 7 down to 0, with bit 7 first.
- R6: No decimal digit is offered before the conversion ends. When `out_ready` is held high, the first decimal digit is accepted no earlier than 32 cycles after the cycle in which the value was accepted.
- R7: `out_last` is high on the final character ('.') and on no other character of the line.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` keep their values into the next cycle.
- R9: After the handshake of the final character, `in_ready` is high and `out_valid` is low in the next cycle.
- R10: Every character offered is printable ASCII, in the range 0x20 to 0x7E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A value is offered on `in_data` |
| in_ready | output | 1 | The printer is idle and will take a value |
| in_data | input | VAL_W | Unsigned value to print |
| out_valid | output | 1 | A character is offered on `out_data` |
| out_ready | input | 1 | Downstream takes the offered character |
| out_data | output | 8 | ASCII character code |
| out_last | output | 1 | Marks the final character of the line |

## Verification
The assertions assume only that reset is applied first. They place no rule on how `in_valid` or `out_ready` behave, so the hold, handshake and printable-text properties must hold under any upstream or downstream pattern. The stimulus relies on this freedom:

- It randomises `out_ready` every cycle.
- In some lines it keeps `in_valid` high with a different value for the whole line.
- It drops `in_valid` before the cycle in which `in_ready` returns, so each line has a known value.

// File: rtl/strfmt_pkg.sv
`timescale 1ns/1ps
package strfmt_pkg;

  localparam int CHAR_W = 8;
  localparam int LEN_W  = 5;
  localparam int OFF_W  = 5;

  typedef enum logic [2:0] {
    K_TEXT  = 3'd0,
    K_HEXLO = 3'd1,
    K_HEXUP = 3'd2,
    K_DEC   = 3'd3,
    K_OCT   = 3'd4,
    K_BIN   = 3'd5
  } kind_e;

  typedef struct packed {
    kind_e              kind;
    logic [LEN_W-1:0]   len;
    logic [OFF_W-1:0]   toff;
  } seg_t;

  localparam int SEG_COUNT = 11;
  localparam int TEXT_LEN  = 31;
  // all constant text pieces back to back; a text segment points into it
  localparam logic [CHAR_W*TEXT_LEN-1:0] TEXT_ROM = "hex 0x, dec , HEX , oct , bin .";

  function automatic seg_t mk_seg(input kind_e k, input int l, input int o);
    seg_t s;
    s.kind = k;
    s.len  = LEN_W'(l);
    s.toff = OFF_W'(o);
    return s;
  endfunction

  // format layout, emitted in index order
  function automatic seg_t seg_at(input int idx);
    case (idx)
      0:       return mk_seg(K_TEXT,  6, 0);
      1:       return mk_seg(K_HEXLO, 8, 0);
      2:       return mk_seg(K_TEXT,  6, 6);
      3:       return mk_seg(K_DEC,  10, 0);
      4:       return mk_seg(K_TEXT,  6, 12);
      5:       return mk_seg(K_HEXUP, 8, 0);
      6:       return mk_seg(K_TEXT,  6, 18);
      7:       return mk_seg(K_OCT,  11, 0);
      8:       return mk_seg(K_TEXT,  6, 24);
      9:       return mk_seg(K_BIN,   8, 0);
      default: return mk_seg(K_TEXT,  1, 30);
    endcase
  endfunction

  function automatic int bits_per_digit(input kind_e k);
    case (k)
      K_HEXLO, K_HEXUP, K_DEC: return 4;
      K_OCT:                   return 3;
      K_BIN:                   return 1;
      default:                 return 0;
    endcase
  endfunction

  function automatic int total_chars();
    int n = 0;
    for (int i = 0; i < SEG_COUNT; i++) n += int'(seg_at(i).len);
    return n;
  endfunction

  // widest slice of the raw value that any non-decimal field reads
  function automatic int max_field_bits();
    int m = 0;
    for (int i = 0; i < SEG_COUNT; i++) begin
      seg_t s = seg_at(i);
      if (s.kind != K_DEC && int'(s.len) * bits_per_digit(s.kind) > m)
        m = int'(s.len) * bits_per_digit(s.kind);
    end
    return m;
  endfunction

  localparam int TOTAL_CHARS = total_chars();

endpackage

// File: rtl/strfmt_bcd.sv
`timescale 1ns/1ps
module strfmt_bcd #(
  parameter int VAL_W  = 32,
  parameter int DIGITS = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [VAL_W-1:0]   bin_in,
  output logic               busy,
  output logic [4*DIGITS-1:0] bcd_out
);
  localparam int BCD_W = 4 * DIGITS;
  localparam int CNT_W = $clog2(VAL_W + 1);

  logic [VAL_W-1:0] bin_q;
  logic [BCD_W-1:0] bcd_q;
  logic [BCD_W-1:0] adj;
  logic [CNT_W-1:0] cnt_q;

  // add-3 correction of every decade before the next shift
  for (genvar g = 0; g < DIGITS; g++) begin : g_adj
    assign adj[4*g +: 4] = (bcd_q[4*g +: 4] >= 4'd5) ? bcd_q[4*g +: 4] + 4'd3
                                                     : bcd_q[4*g +: 4];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bin_q <= '0;
      bcd_q <= '0;
      cnt_q <= '0;
    end else if (start) begin
      bin_q <= bin_in;
      bcd_q <= '0;
      cnt_q <= CNT_W'(VAL_W);
    end else if (cnt_q != '0) begin
      bcd_q <= BCD_W'({adj, bin_q[VAL_W-1]});
      bin_q <= bin_q << 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy    = (cnt_q != '0);
  assign bcd_out = bcd_q;
endmodule

// File: rtl/strfmt_walker.sv
`timescale 1ns/1ps
module strfmt_walker
  import strfmt_pkg::*;
#(
  parameter int SEG_IDX_W = $clog2(SEG_COUNT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 step,
  output logic                 active,
  output seg_t                 cur_seg,
  output logic [LEN_W-1:0]     pos,
  output logic                 final_char
);
  logic [SEG_IDX_W-1:0] seg_idx;
  logic                 at_end;
  logic                 last_seg;

  assign cur_seg    = seg_at(int'(seg_idx));
  assign at_end     = (pos == cur_seg.len - LEN_W'(1));
  assign last_seg   = (seg_idx == SEG_IDX_W'(SEG_COUNT - 1));
  assign final_char = active && at_end && last_seg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      seg_idx <= '0;
      pos     <= '0;
    end else if (start) begin
      active  <= 1'b1;
      seg_idx <= '0;
      pos     <= '0;
    end else if (active && step) begin
      if (at_end) begin
        pos <= '0;
        if (last_seg) active  <= 1'b0;
        else          seg_idx <= seg_idx + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/strfmt_glyph.sv
`timescale 1ns/1ps
module strfmt_glyph
  import strfmt_pkg::*;
(
  input  kind_e              kind,
  input  logic [3:0]         digit,
  input  logic [CHAR_W-1:0]  text_char,
  output logic [CHAR_W-1:0]  glyph
);
  logic [CHAR_W-1:0] dig_w;
  assign dig_w = {{(CHAR_W-4){1'b0}}, digit};

  always_comb begin
    case (kind)
      K_TEXT:  glyph = text_char;
      K_HEXUP: glyph = (digit < 4'd10) ? 8'h30 + dig_w : 8'h41 + dig_w - 8'd10;
      default: glyph = (digit < 4'd10) ? 8'h30 + dig_w : 8'h61 + dig_w - 8'd10;
    endcase
  end
endmodule

// File: rtl/strfmt_emitter.sv
`timescale 1ns/1ps
module strfmt_emitter
  import strfmt_pkg::*;
#(
  parameter int VAL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VAL_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last
);
  localparam int BCD_DIGITS = (VAL_W * 30103) / 100000 + 1;
  localparam int FIELD_W    = max_field_bits();
  localparam int EXT_W      = (FIELD_W > VAL_W) ? FIELD_W : VAL_W;

  logic                    accept;
  logic                    step;
  logic                    active;
  logic                    final_char;
  logic                    bcd_busy;
  logic [VAL_W-1:0]        val_q;
  logic [EXT_W-1:0]        val_ext;
  logic [4*BCD_DIGITS-1:0] bcd_val;
  seg_t                    cur;
  logic [LEN_W-1:0]        pos;
  logic [3:0]              digit;
  logic [CHAR_W-1:0]       text_char;
  int                      dpos;

  assign in_ready = !active;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)      val_q <= '0;
    else if (accept) val_q <= in_data;
  end
  assign val_ext = EXT_W'(val_q);

  strfmt_bcd #(.VAL_W(VAL_W), .DIGITS(BCD_DIGITS)) u_bcd (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .bin_in  (in_data),
    .busy    (bcd_busy),
    .bcd_out (bcd_val)
  );

  strfmt_walker u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .step       (step),
    .active     (active),
    .cur_seg    (cur),
    .pos        (pos),
    .final_char (final_char)
  );

  // digit picked most significant first: position 0 is the top slice
  always_comb begin
    dpos      = int'(cur.len) - 1 - int'(pos);
    digit     = '0;
    text_char = '0;
    case (cur.kind)
      K_DEC:            digit = 4'(bcd_val >> (4 * dpos));
      K_HEXLO, K_HEXUP: digit = 4'(val_ext >> (4 * dpos));
      K_OCT:            digit = {1'b0, 3'(val_ext >> (3 * dpos))};
      K_BIN:            digit = {3'b000, 1'(val_ext >> dpos)};
      default:          text_char = CHAR_W'(TEXT_ROM >>
                          (CHAR_W * (TEXT_LEN - 1 - (int'(cur.toff) + int'(pos)))));
    endcase
  end

  strfmt_glyph u_glyph (
    .kind      (cur.kind),
    .digit     (digit),
    .text_char (text_char),
    .glyph     (out_data)
  );

  assign out_valid = active && !(cur.kind == K_DEC && bcd_busy);
  assign out_last  = final_char;
  assign step      = out_valid && out_ready;
endmodule

// File: rtl/strfmt_emitter_chk.sv
`timescale 1ns/1ps
module strfmt_emitter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready && !out_valid);

  assert_print_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data >= 8'h20 && out_data <= 8'h7e));
endmodule

bind strfmt_emitter strfmt_emitter_chk u_chk (.*);

// File: tb/strfmt_emitter_bench.sv
`timescale 1ns/1ps
module strfmt_emitter_bench;
  localparam int N = 76;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_b [0:N-1];
  logic [7:0] rx    [0:N-1];
  int ep;

  always #2 clk = ~clk;

  strfmt_emitter u_strfmt_emitter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  function automatic void put(input logic [7:0] c);
    exp_b[ep] = c;
    ep++;
  endfunction

  function automatic void put_s(input string s);
    for (int i = 0; i < s.len(); i++) put(s[i]);
  endfunction

  function automatic logic [7:0] hexc(input int n, input bit up);
    if (n < 10) return 8'(48 + n);
    return up ? 8'(65 + n - 10) : 8'(97 + n - 10);
  endfunction

  function automatic void build_exp(input logic [31:0] v);
    longint unsigned t;
    int dd [10];
    ep = 0;
    put_s("hex 0x");
    for (int d = 7; d >= 0; d--) put(hexc(int'((v >> (4*d)) & 32'hf), 1'b0));
    put_s(", dec ");
    t = longint'(v);
    for (int k = 0; k < 10; k++) begin dd[k] = int'(t % 10); t = t / 10; end
    for (int k = 9; k >= 0; k--) put(8'(48 + dd[k]));
    put_s(", HEX ");
    for (int d = 7; d >= 0; d--) put(hexc(int'((v >> (4*d)) & 32'hf), 1'b1));
    put_s(", oct ");
    t = longint'(v);
    for (int d = 10; d >= 0; d--) put(8'(48 + ((t >> (3*d)) & 7)));
    put_s(", bin ");
    for (int d = 7; d >= 0; d--) put(8'(48 + ((v >> d) & 1)));
    put_s(".");
  endfunction

  function automatic string region_req(input int i);
    if (i < 6)  return "R2";
    if (i < 14) return "R3";
    if (i < 20) return "R2";
    if (i < 30) return "R4";
    if (i < 36) return "R2";
    if (i < 44) return "R3";
    if (i < 50) return "R2";
    if (i < 61) return "R5";
    if (i < 67) return "R2";
    if (i < 75) return "R5";
    return "R2";
  endfunction

  task automatic check_region(input string rq);
    bit ok = 1'b1;
    int bad = 0;
    for (int i = 0; i < N; i++)
      if (ok && region_req(i) == rq && rx[i] !== exp_b[i]) begin ok = 1'b0; bad = i; end
    check(ok, rq, $sformatf("char %0d", bad), longint'(rx[bad]), longint'(exp_b[bad]));
  endtask

  task automatic run_one(input logic [31:0] v, input bit junk, input int stall_pct);
    int got = 0, cyc = 0, dec_cyc = -1, bad_last = -1;
    bit prev_stall = 1'b0, hold_ok = 1'b1, rdy_ok = 1'b1, print_ok = 1'b1;
    logic [7:0] prev_d = '0;
    build_exp(v);
    @(negedge clk);
    check(in_ready === 1'b1, "R1", "in_ready when idle", longint'(in_ready), 1);
    in_valid = 1'b1; in_data = v; out_ready = 1'b0;
    @(negedge clk);
    in_valid = junk; in_data = ~v;
    while (got < N && cyc < 5000) begin
      out_ready = ($urandom % 100) >= stall_pct;
      if (in_ready) rdy_ok = 1'b0;
      if (prev_stall && (!out_valid || out_data !== prev_d)) hold_ok = 1'b0;
      if (out_valid && (out_data < 8'h20 || out_data > 8'h7e)) print_ok = 1'b0;
      if (out_valid && out_ready) begin
        rx[got] = out_data;
        if (out_last !== (got == N-1) && bad_last < 0) bad_last = got;
        if (got == 20) dec_cyc = cyc;
        got++;
      end
      prev_stall = out_valid && !out_ready;
      prev_d = out_data;
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    check(got == N, "R2", "character count", got, N);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R9", "idle after final char",
          longint'({in_ready, out_valid}), 2);
    check(rdy_ok, "R1", "in_ready low during line", 1, 0);
    check(hold_ok, "R8", "output held under stall", 0, 1);
    check(print_ok, "R10", "printable output", 0, 1);
    check(bad_last < 0, "R7", "last flag position", bad_last, N-1);
    check_region("R2");
    check_region("R3");
    check_region("R4");
    check_region("R5");
    if (junk) check(rx[6] === exp_b[6] && rx[29] === exp_b[29], "R1",
                    "busy input ignored", longint'(rx[29]), longint'(exp_b[29]));
    if (stall_pct == 0) check(dec_cyc >= 32, "R6", "first decimal digit cycle", dec_cyc, 32);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R1", "reset in_ready", longint'(in_ready), 1);
    check(out_valid === 1'b0, "R9", "reset out_valid", longint'(out_valid), 0);
    run_one(32'h0000_0000, 1'b0, 0);
    run_one(32'hFFFF_FFFF, 1'b0, 0);
    run_one(32'h0000_ABCD, 1'b1, 0);
    run_one(32'h1234_5678, 1'b0, 40);
    run_one(32'h8000_0001, 1'b1, 70);
    for (int k = 0; k < 12; k++)
      run_one($urandom, k[0], (k % 3) * 30);
    finish_up();
  end
endmodule